// File: doc/BRIEF.md
# Cascadable Four-Level LCD Column Latch

This block is the digital core of a 160-column LCD column driver that can be chained with others to cover a wide panel. Display data arrives four bits at a time. Each falling edge of a data clock writes one nibble into a line latch, but only while the block's active-low chain enable input is asserted. After forty nibbles the line is full. The block then asserts its own chain enable output, which hands the data stream to the next device, and it ignores all further data clocks. A direction select picks the fill order: from column 1 upward or from column 160 downward. It also swaps which of the two chain pins acts as input and which acts as output.

A falling edge on the load strobe copies the whole line latch into a display latch in one step. The same edge re-arms the chain so that the next line can be taken. Each column's displayed bit is combined with the AC frame polarity and an active-low blanking input to give a 2-bit drive-level code for the analog output stage. All inputs are sampled on a single system clock. Falling edges are found by comparing each input with its value one clock earlier.

Top module: `lcd_seg_latch`

## Requirements
- R1: After reset both latches and the nibble counter are clear. With frame=0 and blank_n=1 every column therefore reports code 01, and both chain outputs are high.
- R2: A nibble is taken only when a high-to-low transition of `dclk` is seen while the active chain input is low. The active chain input is `chain_a_i` when `dir_sel`=1 and `chain_b_i` when `dir_sel`=0. Falling edges seen while the active chain input is high change nothing.
- R3: With `dir_sel`=1, nibble n (counting from 0) writes bit j of `dat` into column 4n+j+1.
- R4: With `dir_sel`=0, nibble n writes bit j of `dat` into column 160-4n-j.
- R5: With `dir_sel`=0, `chain_a_o` is the chain output and `chain_b_o` is held high. With `dir_sel`=1, `chain_b_o` is the chain output and `chain_a_o` is held high.
- R6: The chain output goes low once the 40th nibble has been taken. From then on, data clock edges leave the line latch unchanged until the next load.
- R7: A falling edge of `ldstb` copies the line latch into the display latch. The line latch keeps its contents. The nibble counter returns to zero and the chain output returns high.
- R8: If a load edge and a data clock edge are seen in the same cycle, the load takes effect and that nibble is discarded. The next nibble accepted goes to slot 0.
- R9: Column c reports its code at `lvl[2c-1:2c-2]`. With blank_n=1, the pair {display bit, frame} maps as follows: {0,0} gives 01, {1,0} gives 00, {0,1} gives 10, {1,1} gives 11.
- R10: While `blank_n`=0, every column reports 00, whatever the data or frame.
- R11: `lvl` changes only through the display latch, `frame` or `blank_n`. Nibbles written into the line latch do not appear on `lvl` before a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dclk | input | 1 | Data clock; a nibble is taken on its falling edge |
| dat | input | 4 | Display data nibble |
| ldstb | input | 1 | Load strobe; falling edge moves the line into the display latch |
| dir_sel | input | 1 | Fill direction and chain pin role select |
| chain_a_i | input | 1 | Chain enable input used when dir_sel=1, active low |
| chain_b_i | input | 1 | Chain enable input used when dir_sel=0, active low |
| chain_a_o | output | 1 | Chain enable output when dir_sel=0, otherwise high |
| chain_b_o | output | 1 | Chain enable output when dir_sel=1, otherwise high |
| frame | input | 1 | AC frame polarity |
| blank_n | input | 1 | Active-low display blanking |
| lvl | output | 320 | Two-bit drive code per column |

## Verification
A load strobe edge and a data clock edge can be detected on the same system clock, so loading and nibble capture compete for the nibble counter. The bench drives both strobes high together and releases them on the same clock, after two nibbles of a line are already in. It then checks that the display latch shows the line as it stood before that edge, with the coincident nibble found in no column. Finally, one more nibble and a second load must land in columns 1 to 4 while the earlier second nibble stays in columns 5 to 8.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  typedef enum logic [1:0] {
    LVL_V1  = 2'b00,
    LVL_V3  = 2'b01,
    LVL_V4  = 2'b10,
    LVL_VEE = 2'b11
  } drv_lvl_e;

  function automatic drv_lvl_e pick_level(input logic pix, input logic frm,
                                          input logic blank_n);
    drv_lvl_e r;
    if (!blank_n) begin
      r = LVL_V1;
    end else begin
      case ({pix, frm})
        2'b00:   r = LVL_V3;
        2'b10:   r = LVL_V1;
        2'b01:   r = LVL_V4;
        default: r = LVL_VEE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/seg_edge_det.sv
module seg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic fall_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sig_i;

endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl #(
  parameter int NSTEP = 40,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sh_fall_i,
  input  logic          ld_fall_i,
  input  logic          dir_sel_i,
  input  logic          chain_a_i,
  input  logic          chain_b_i,
  output logic          wr_en_o,
  output logic [CW-1:0] slot_o,
  output logic          chain_a_o,
  output logic          chain_b_o
);

  localparam logic [CW-1:0] LAST = CW'(NSTEP);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          full;
  logic          chain_in_n;
  logic          cnt_en;

  assign chain_in_n = dir_sel_i ? chain_a_i : chain_b_i;
  assign full       = (cnt_q == LAST);
  assign wr_en_o    = sh_fall_i & ~ld_fall_i & ~chain_in_n & ~full;
  assign cnt_en     = ld_fall_i | wr_en_o;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_fall_i) begin
      cnt_d = '0;
    end else if (wr_en_o) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign slot_o    = cnt_q;
  assign chain_a_o = dir_sel_i ? 1'b1 : ~full;
  assign chain_b_o = dir_sel_i ? ~full : 1'b1;

endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch #(
  parameter int NCOL = 160,
  parameter int NW   = 4,
  parameter int CW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [CW-1:0]   slot_i,
  input  logic            dir_sel_i,
  input  logic [NW-1:0]   dat_i,
  input  logic            ld_fall_i,
  output logic [NCOL-1:0] line_o,
  output logic [NCOL-1:0] disp_o
);

  logic [NCOL-1:0] line_q;
  logic [NCOL-1:0] line_d;
  logic [NCOL-1:0] disp_q;
  logic [NCOL-1:0] disp_d;

  always_comb begin
    line_d = line_q;
    for (int j = 0; j < NW; j++) begin
      int base;
      int idx;
      base = int'(slot_i) * NW;
      idx  = dir_sel_i ? (base + j) : (NCOL - 1 - base - j);
      if (wr_en_i && idx >= 0 && idx < NCOL) begin
        line_d[idx] = dat_i[j];
      end
    end
  end

  always_comb begin
    disp_d = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (wr_en_i) begin
      line_q <= line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
    end else if (ld_fall_i) begin
      disp_q <= disp_d;
    end
  end

  assign line_o = line_q;
  assign disp_o = disp_q;

endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
  import lcd_seg_pkg::*;
#(
  parameter int NCOL = 160
) (
  input  logic [NCOL-1:0]   disp_i,
  input  logic              frame_i,
  input  logic              blank_n_i,
  output logic [2*NCOL-1:0] lvl_o
);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    drv_lvl_e code;
    always_comb begin
      code = pick_level(disp_i[c], frame_i, blank_n_i);
    end
    assign lvl_o[2*c +: 2] = code;
  end

endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
  parameter int NCOL = 160,
  parameter int NW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk,
  input  logic [NW-1:0]     dat,
  input  logic              ldstb,
  input  logic              dir_sel,
  input  logic              chain_a_i,
  input  logic              chain_b_i,
  output logic              chain_a_o,
  output logic              chain_b_o,
  input  logic              frame,
  input  logic              blank_n,
  output logic [2*NCOL-1:0] lvl
);

  localparam int NSTEP = NCOL / NW;
  localparam int CW    = $clog2(NSTEP + 1);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            sh_fall;
  logic            ld_fall;
  logic            wr_en;
  logic [CW-1:0]   slot;
  logic [NCOL-1:0] line_q;
  logic [NCOL-1:0] disp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  seg_edge_det u_dclk_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sig_i (dclk),
    .fall_o(sh_fall)
  );

  seg_edge_det u_load_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sig_i (ldstb),
    .fall_o(ld_fall)
  );

  seg_fill_ctrl #(.NSTEP(NSTEP), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sh_fall_i(sh_fall),
    .ld_fall_i(ld_fall),
    .dir_sel_i(dir_sel),
    .chain_a_i(chain_a_i),
    .chain_b_i(chain_b_i),
    .wr_en_o  (wr_en),
    .slot_o   (slot),
    .chain_a_o(chain_a_o),
    .chain_b_o(chain_b_o)
  );

  seg_line_latch #(.NCOL(NCOL), .NW(NW), .CW(CW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en_i  (wr_en),
    .slot_i   (slot),
    .dir_sel_i(dir_sel),
    .dat_i    (dat),
    .ld_fall_i(ld_fall),
    .line_o   (line_q),
    .disp_o   (disp_q)
  );

  seg_level_enc #(.NCOL(NCOL)) u_enc (
    .disp_i   (disp_q),
    .frame_i  (frame),
    .blank_n_i(blank_n),
    .lvl_o    (lvl)
  );

endmodule

// File: rtl/lcd_seg_latch_chk.sv
module lcd_seg_latch_chk #(
  parameter int NCOL  = 160,
  parameter int NSTEP = 40,
  parameter int CW    = 6
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              dir_sel,
  input logic              chain_a_o,
  input logic              chain_b_o,
  input logic              blank_n,
  input logic [2*NCOL-1:0] lvl,
  input logic              ld_fall,
  input logic [CW-1:0]     slot,
  input logic [NCOL-1:0]   line_q,
  input logic [NCOL-1:0]   disp_q
);

  localparam logic [CW-1:0] LAST = CW'(NSTEP);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_int_n)
    slot <= LAST);

  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slot == LAST && !ld_fall) |=> $stable(line_q));

  a_r7_load_copy: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_fall |=> (disp_q == $past(line_q)));

  a_r7_line_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_fall |=> $stable(line_q));

  a_r7_chain_rearm: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_fall |=> (chain_a_o && chain_b_o));

  a_r8_slot_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_fall |=> (slot == '0));

  a_r5_idle_pin: assert property (@(posedge clk) disable iff (!rst_int_n)
    dir_sel ? chain_a_o : chain_b_o);

  a_r10_blank: assert property (@(posedge clk) disable iff (!rst_int_n)
    !blank_n |-> (lvl == '0));

  a_r11_disp_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ld_fall |=> $stable(disp_q));

endmodule

bind lcd_seg_latch lcd_seg_latch_chk #(.NCOL(NCOL), .NSTEP(NSTEP), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .dir_sel  (dir_sel),
  .chain_a_o(chain_a_o),
  .chain_b_o(chain_b_o),
  .blank_n  (blank_n),
  .lvl      (lvl),
  .ld_fall  (ld_fall),
  .slot     (slot),
  .line_q   (line_q),
  .disp_q   (disp_q)
);

// File: tb/sim_lcd_seg_latch.sv
`timescale 1ns/1ps
module sim_lcd_seg_latch;

  localparam int NCOL  = 160;
  localparam int NW    = 4;
  localparam int NSTEP = NCOL / NW;

  // R9/R10 vectors: {frame, blank_n, code for bit 1, code for bit 0}
  localparam logic [5:0] VEC [6] = '{
    {1'b0, 1'b1, 2'b00, 2'b01},
    {1'b1, 1'b1, 2'b11, 2'b10},
    {1'b0, 1'b0, 2'b00, 2'b00},
    {1'b1, 1'b0, 2'b00, 2'b00},
    {1'b1, 1'b1, 2'b11, 2'b10},
    {1'b0, 1'b1, 2'b00, 2'b01}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dclk;
  logic [NW-1:0]     dat;
  logic              ldstb;
  logic              dir_sel;
  logic              chain_a_i;
  logic              chain_b_i;
  logic              chain_a_o;
  logic              chain_b_o;
  logic              frame;
  logic              blank_n;
  logic [2*NCOL-1:0] lvl;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  logic [NCOL-1:0] exp_line;
  logic [NCOL-1:0] exp_disp;
  int exp_slot;

  always #2.5 clk = ~clk;

  lcd_seg_latch u0 (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .dat(dat), .ldstb(ldstb),
    .dir_sel(dir_sel), .chain_a_i(chain_a_i), .chain_b_i(chain_b_i),
    .chain_a_o(chain_a_o), .chain_b_o(chain_b_o), .frame(frame),
    .blank_n(blank_n), .lvl(lvl)
  );

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_disp(input string tag, input logic [1:0] c1, input logic [1:0] c0);
    int bad = 0;
    int col = 0;
    logic [1:0] a = 2'b00;
    logic [1:0] e = 2'b00;
    checks++;
    for (int c = 0; c < NCOL; c++) begin
      logic [1:0] ee;
      ee = exp_disp[c] ? c1 : c0;
      if (lvl[2*c +: 2] !== ee) begin
        if (bad == 0) begin
          col = c + 1; a = lvl[2*c +: 2]; e = ee;
        end
        bad++;
      end
    end
    if (bad != 0) begin
      failures++;
      $display("FAIL %s column %0d actual=%b expected=%b (%0d columns wrong)",
               tag, col, a, e, bad);
    end
  endtask

  task automatic send(input logic [NW-1:0] v);
    bit acc;
    acc = (dir_sel ? !chain_a_i : !chain_b_i) && (exp_slot < NSTEP);
    @(negedge clk); dat = v; dclk = 1'b1;
    @(negedge clk); dclk = 1'b0;
    @(negedge clk);
    if (acc) begin
      for (int j = 0; j < NW; j++) begin
        if (dir_sel) exp_line[exp_slot*NW + j] = v[j];
        else         exp_line[NCOL-1 - exp_slot*NW - j] = v[j];
      end
      exp_slot++;
    end
  endtask

  task automatic load_line(input bit with_data, input logic [NW-1:0] v);
    @(negedge clk); ldstb = 1'b1; dat = v; if (with_data) dclk = 1'b1;
    @(negedge clk); ldstb = 1'b0; dclk = 1'b0;
    @(negedge clk);
    exp_disp = exp_line;
    exp_slot = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dclk = 1'b0; dat = '0; ldstb = 1'b0; dir_sel = 1'b1;
    chain_a_i = 1'b1; chain_b_i = 1'b1; frame = 1'b0; blank_n = 1'b1;
    exp_line = '0; exp_disp = '0; exp_slot = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_disp("R1 reset codes", 2'b00, 2'b01);
    check1("R1 chain_a_o after reset", chain_a_o, 1'b1);
    check1("R1 chain_b_o after reset", chain_b_o, 1'b1);

    // R3 upward fill, R6 full, R11 no early show
    dir_sel = 1'b1; chain_a_i = 1'b0;
    for (int n = 0; n < 20; n++) send(4'((n*7 + 3) & 15));
    check_disp("R11 line hidden before load", 2'b00, 2'b01);
    check1("R6 chain_b_o mid line", chain_b_o, 1'b1);
    for (int n = 20; n < NSTEP; n++) send(4'((n*7 + 3) & 15));
    check1("R6 chain_b_o when full", chain_b_o, 1'b0);
    check1("R5 chain_a_o idle when dir=1", chain_a_o, 1'b1);
    send(4'hF); send(4'h0);
    load_line(1'b0, 4'h0);
    check_disp("R3 upward fill and R6 extra ignored", 2'b00, 2'b01);
    check1("R7 chain_b_o rearmed", chain_b_o, 1'b1);

    // R2 gating, R4 downward fill, R5 pin roles
    dir_sel = 1'b0; chain_a_i = 1'b1; chain_b_i = 1'b1;
    send(4'hF); send(4'hA); send(4'h5);
    check1("R5 chain_a_o output high while idle", chain_a_o, 1'b1);
    check1("R5 chain_b_o held high when dir=0", chain_b_o, 1'b1);
    chain_b_i = 1'b0;
    for (int n = 0; n < NSTEP; n++) send(4'((n*11 + 6) & 15));
    check1("R6 chain_a_o when full", chain_a_o, 1'b0);
    check1("R5 chain_b_o stays high", chain_b_o, 1'b1);
    load_line(1'b0, 4'h0);
    check_disp("R4 downward fill and R2 gated edges", 2'b00, 2'b01);
    check1("R7 chain_a_o rearmed", chain_a_o, 1'b1);

    // R7 line kept after load
    load_line(1'b0, 4'h0);
    check_disp("R7 line latch retained", 2'b00, 2'b01);

    // R8 coincident load and data edge
    dir_sel = 1'b1; chain_a_i = 1'b0; chain_b_i = 1'b1;
    send(4'h9); send(4'h6);
    load_line(1'b1, 4'hC);
    check_disp("R8 load wins on coincidence", 2'b00, 2'b01);
    send(4'h3);
    load_line(1'b0, 4'h0);
    check_disp("R8 next nibble to slot 0", 2'b00, 2'b01);

    // R9 / R10 vector table
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      frame = VEC[k][5]; blank_n = VEC[k][4];
      @(negedge clk);
      if (VEC[k][4]) check_disp("R9 level table", VEC[k][3:2], VEC[k][1:0]);
      else           check_disp("R10 blanking", VEC[k][3:2], VEC[k][1:0]);
    end

    // R10 blanking while a line fills and loads
    blank_n = 1'b0;
    for (int n = 0; n < 4; n++) send(4'hF);
    load_line(1'b0, 4'h0);
    check_disp("R10 blank after load", 2'b00, 2'b00);
    blank_n = 1'b1;
    @(negedge clk);
    check_disp("R9 unblank shows data", 2'b00, 2'b01);

    // R1 reset clears latches again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_line = '0; exp_disp = '0; exp_slot = 0;
    check_disp("R1 second reset", 2'b00, 2'b01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule